// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block connects a synchronous request port to an asynchronous sixteen-bit DRAM that shares its address pins between row and column. A request carries a 22-bit word address, a write flag, two byte enables and write data. The controller splits the address into a 12-bit row (upper bits) and a 10-bit column (lower bits). It opens the row with the row strobe and then issues the column cycle with one column strobe per byte lane.

The row stays open after an access. A later request to the same row is served as a page cycle, in which only the column strobes toggle. A request to another row, an idle timeout or a refresh closes the row and waits out the precharge time. An internal timer requests a column-before-row refresh at a fixed period. That refresh takes precedence over new requests. All timing values are counts of clock cycles taken from parameters.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is applied and for at least T_INIT cycles after it is released, the row strobe, both column strobes, the write strobe and the output-enable strobe are high, and req_ready is low.
- R2: The row address req_addr[21:10] is on dram_addr when the row strobe falls. The column address req_addr[9:0] is on dram_addr[9:0], with dram_addr[11:10] at zero, when the column strobes fall. The column address stays stable while any column strobe is low during an access.
- R3: At least T_RCD cycles pass between the row strobe falling and the first column strobe falling in the same row.
- R4: req_be[0] enables dram_casl_n, which covers data bits 7:0. req_be[1] enables dram_cash_n, which covers bits 15:8. A lane that is not enabled keeps its strobe high, and the enabled strobes fall and rise in the same cycle.
- R5: For a write, dram_we_n is low at least one cycle before the column strobes fall and stays low until they rise. dram_oe_n stays high, and the enabled byte lanes of dram_dq carry the write data.
- R6: For a read, dram_oe_n is low. The data bus is sampled T_RD cycles after the column strobes fall, and rsp_valid is high for exactly one cycle with the data. Bytes of lanes that were not enabled read as zero.
- R7: A request to the row that is already open produces no new row activation. The row strobe stays low and only the column strobes toggle.
- R8: Before a different row is opened, the row strobe stays high for at least T_RP cycles.
- R9: Every REF_INTERVAL cycles, one refresh is performed. Both column strobes go low while the row strobe is high, the write strobe stays high, and then the row strobe falls.
- R10: A pending refresh holds req_ready low and is served before the next request. The row strobe is high for at least T_RP cycles before the refresh row strobe falls.
- R11: An open row with no further request is closed within IDLE_TO plus a few cycles after its last access. It is not closed within IDLE_TO/2 cycles.
- R12: A request is taken only on a cycle with req_valid and req_ready both high. req_ready is low in the cycle after a request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in [21:10], column in [9:0] |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| dram_ras_n | output | 1 | Row strobe |
| dram_casl_n | output | 1 | Column strobe, low byte |
| dram_cash_n | output | 1 | Column strobe, high byte |
| dram_we_n | output | 1 | Write strobe |
| dram_oe_n | output | 1 | Output enable strobe |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_dq | inout | 16 | Bidirectional data bus |

## Verification
A refresh tick and an incoming request can arrive in the same cycle, and a request can also arrive while a refresh is still pending. The bench provokes this collision by streaming back-to-back writes and reads that alternate between two rows, for longer than one refresh period. It then judges three things: every read returns what was written, at least one refresh happens inside the stream, and the row strobe was high for at least the precharge time before each refresh. A separate directed run lets the refresh timer run with no traffic. It confirms the refresh count and the strobe order of each refresh.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_IDLE,
    ST_RSET,
    ST_ACT,
    ST_OPEN,
    ST_COL,
    ST_CAS,
    ST_PRE,
    ST_REFC,
    ST_REFR,
    ST_REFP
  } fpm_state_e;

  // strobes that are single wires (column strobes are per lane)
  typedef struct packed {
    logic ras_n;
    logic we_n;
    logic oe_n;
  } fpm_ctl_t;

  localparam fpm_ctl_t CTL_QUIET = '{ras_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

endpackage

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
  parameter int INTERVAL = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  localparam int TW = $clog2(INTERVAL);

  logic [TW-1:0] tick_q, tick_d;
  logic          pend_q, pend_d;
  logic          wrap;

  assign wrap = (tick_q == '0);

  always_comb begin
    tick_d = wrap ? TW'(INTERVAL - 1) : tick_q - 1'b1;
    pend_d = pend_q;
    if (ack)  pend_d = 1'b0;
    if (wrap) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= TW'(INTERVAL - 1);
      pend_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/fpm_dq_lanes.sv
module fpm_dq_lanes #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [LANES*LANE_W-1:0]  wdata_in,
  input  logic                     drive,
  input  logic [LANES-1:0]         lane_be,
  input  logic                     capture,
  output logic [LANES*LANE_W-1:0]  rdata,
  inout  wire  [LANES*LANE_W-1:0]  dq
);
  logic [LANES*LANE_W-1:0] wdata_q;
  logic [LANES*LANE_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wdata_q <= '0;
    else if (load) wdata_q <= wdata_in;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dq[l*LANE_W +: LANE_W] = (drive && lane_be[l]) ?
                                    wdata_q[l*LANE_W +: LANE_W] : {LANE_W{1'bz}};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rdata_q[l*LANE_W +: LANE_W] <= '0;
      else if (capture)
        rdata_q[l*LANE_W +: LANE_W] <= lane_be[l] ? dq[l*LANE_W +: LANE_W] : '0;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/fpm_sequencer.sv
module fpm_sequencer
  import fpm_pkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 10,
  parameter int LANES   = 2,
  parameter int T_INIT  = 12500,
  parameter int T_RCD   = 3,
  parameter int T_CAS   = 2,
  parameter int T_RD    = 2,
  parameter int T_CP    = 1,
  parameter int T_RP    = 5,
  parameter int T_CSR   = 1,
  parameter int T_RAS   = 8,
  parameter int IDLE_TO = 64,
  localparam int AW     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [LANES-1:0] req_be,
  input  logic             ref_pend,
  output logic             req_ready,
  output logic             req_take,
  output logic             ref_ack,
  output fpm_ctl_t         ctl,
  output logic [LANES-1:0] cas_n,
  output logic [AW-1:0]    addr,
  output logic             drive,
  output logic [LANES-1:0] lane_be,
  output logic             capture,
  output logic             rsp_valid
);
  localparam int CNT_MAXV = T_INIT + T_RCD + T_CAS + T_RP + T_RAS + T_CSR + T_CP;
  localparam int CNT_W    = $clog2(CNT_MAXV + 1);
  localparam int IDL_W    = $clog2(IDLE_TO + 1);

  fpm_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDL_W-1:0] idle_q, idle_d;
  logic             wr_q, wr_d;
  logic [ROW_W-1:0] row_q, row_d, open_q, open_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [LANES-1:0] be_q, be_d;
  logic             pend_q, pend_d;
  fpm_ctl_t         ctl_q, ctl_d;
  logic [LANES-1:0] cas_q, cas_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic             drv_q, drv_d;
  logic             rsp_q, rsp_d;
  logic             done, take, hit;

  assign done      = (cnt_q == '0);
  assign req_ready = done && !ref_pend && (state_q == ST_IDLE || state_q == ST_OPEN);
  assign take      = req_valid && req_ready;
  assign hit       = (req_row == open_q);
  assign capture   = (state_q == ST_CAS) && !wr_q && (cnt_q == CNT_W'(T_CAS - T_RD));

  always_comb begin
    state_d = state_q;
    cnt_d   = done ? cnt_q : cnt_q - 1'b1;
    idle_d  = idle_q;
    wr_d    = wr_q;
    row_d   = row_q;
    col_d   = col_q;
    be_d    = be_q;
    pend_d  = pend_q;
    open_d  = open_q;
    ctl_d   = ctl_q;
    cas_d   = cas_q;
    addr_d  = addr_q;
    drv_d   = drv_q;
    rsp_d   = capture;
    ref_ack = 1'b0;

    if (take) begin
      wr_d  = req_write;
      row_d = req_row;
      col_d = req_col;
      be_d  = req_be;
    end

    unique case (state_q)
      ST_INIT: if (done) state_d = ST_IDLE;

      ST_IDLE: begin
        if (ref_pend) begin
          state_d = ST_REFC;
          cas_d   = '0;
          cnt_d   = CNT_W'(T_CSR - 1);
          ref_ack = 1'b1;
        end else if (take) begin
          state_d = ST_RSET;
          addr_d  = AW'(req_row);
        end
      end

      ST_RSET: begin
        state_d     = ST_ACT;
        ctl_d.ras_n = 1'b0;
        cnt_d       = CNT_W'(T_RCD - 1);
        open_d      = row_q;
        pend_d      = 1'b0;
      end

      ST_ACT: if (done) begin
        state_d    = ST_COL;
        addr_d     = AW'(col_q);
        ctl_d.we_n = !wr_q;
        ctl_d.oe_n = wr_q;
        drv_d      = wr_q;
      end

      ST_COL: begin
        state_d = ST_CAS;
        cas_d   = ~be_q;
        cnt_d   = CNT_W'(T_CAS - 1);
      end

      ST_CAS: if (done) begin
        state_d    = ST_OPEN;
        cas_d      = '1;
        ctl_d.we_n = 1'b1;
        ctl_d.oe_n = 1'b1;
        drv_d      = 1'b0;
        cnt_d      = CNT_W'(T_CP - 1);
        idle_d     = '0;
      end

      ST_OPEN: begin
        if (idle_q != IDL_W'(IDLE_TO)) idle_d = idle_q + 1'b1;
        if (done && ref_pend) begin
          state_d     = ST_PRE;
          ctl_d.ras_n = 1'b1;
          cnt_d       = CNT_W'(T_RP - 1);
        end else if (take && hit) begin
          state_d    = ST_COL;
          addr_d     = AW'(req_col);
          ctl_d.we_n = !req_write;
          ctl_d.oe_n = req_write;
          drv_d      = req_write;
        end else if (take || (done && idle_q == IDL_W'(IDLE_TO))) begin
          state_d     = ST_PRE;
          ctl_d.ras_n = 1'b1;
          cnt_d       = CNT_W'(T_RP - 1);
          pend_d      = take;
        end
      end

      ST_PRE: if (done) begin
        if (ref_pend) begin
          state_d = ST_REFC;
          cas_d   = '0;
          cnt_d   = CNT_W'(T_CSR - 1);
          ref_ack = 1'b1;
        end else if (pend_q) begin
          state_d = ST_RSET;
          addr_d  = AW'(row_q);
        end else begin
          state_d = ST_IDLE;
        end
      end

      ST_REFC: if (done) begin
        state_d     = ST_REFR;
        ctl_d.ras_n = 1'b0;
        cnt_d       = CNT_W'(T_RAS - 1);
      end

      ST_REFR: if (done) begin
        state_d     = ST_REFP;
        ctl_d.ras_n = 1'b1;
        cas_d       = '1;
        cnt_d       = CNT_W'(T_RP - 1);
      end

      ST_REFP: if (done) begin
        if (pend_q) begin
          state_d = ST_RSET;
          addr_d  = AW'(row_q);
        end else begin
          state_d = ST_IDLE;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      cnt_q   <= CNT_W'(T_INIT - 1);
      idle_q  <= '0;
      wr_q    <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      be_q    <= '0;
      pend_q  <= 1'b0;
      open_q  <= '0;
      ctl_q   <= CTL_QUIET;
      cas_q   <= '1;
      addr_q  <= '0;
      drv_q   <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idle_q  <= idle_d;
      wr_q    <= wr_d;
      row_q   <= row_d;
      col_q   <= col_d;
      be_q    <= be_d;
      pend_q  <= pend_d;
      open_q  <= open_d;
      ctl_q   <= ctl_d;
      cas_q   <= cas_d;
      addr_q  <= addr_d;
      drv_q   <= drv_d;
      rsp_q   <= rsp_d;
    end
  end

  assign req_take  = take;
  assign ctl       = ctl_q;
  assign cas_n     = cas_q;
  assign addr      = addr_q;
  assign drive     = drv_q;
  assign lane_be   = be_q;
  assign rsp_valid = rsp_q;
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W        = 12,
  parameter int COL_W        = 10,
  parameter int LANE_W       = 8,
  parameter int T_INIT       = 12500,
  parameter int T_RCD        = 3,
  parameter int T_CAS        = 2,
  parameter int T_RD         = 2,
  parameter int T_CP         = 1,
  parameter int T_RP         = 5,
  parameter int T_CSR        = 1,
  parameter int T_RAS        = 8,
  parameter int REF_INTERVAL = 1950,
  parameter int IDLE_TO      = 64,
  localparam int LANES       = 2,
  localparam int DW          = LANES * LANE_W,
  localparam int AW          = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [LANES-1:0]       req_be,
  input  logic [DW-1:0]          req_wdata,
  output logic                   rsp_valid,
  output logic [DW-1:0]          rsp_rdata,
  output logic                   dram_ras_n,
  output logic                   dram_casl_n,
  output logic                   dram_cash_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [AW-1:0]          dram_addr,
  inout  wire  [DW-1:0]          dram_dq
);
  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             ref_pend, ref_ack, req_take, drive, capture;
  fpm_ctl_t         ctl;
  logic [LANES-1:0] cas_n, lane_be;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  fpm_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk (clk), .rst_n (rst_sync_n), .ack (ref_ack), .pend (ref_pend)
  );

  fpm_sequencer #(
    .ROW_W (ROW_W), .COL_W (COL_W), .LANES (LANES), .T_INIT (T_INIT),
    .T_RCD (T_RCD), .T_CAS (T_CAS), .T_RD (T_RD), .T_CP (T_CP),
    .T_RP (T_RP), .T_CSR (T_CSR), .T_RAS (T_RAS), .IDLE_TO (IDLE_TO)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_row   (req_addr[ROW_W+COL_W-1:COL_W]),
    .req_col   (req_addr[COL_W-1:0]),
    .req_be    (req_be),
    .ref_pend  (ref_pend),
    .req_ready (req_ready),
    .req_take  (req_take),
    .ref_ack   (ref_ack),
    .ctl       (ctl),
    .cas_n     (cas_n),
    .addr      (dram_addr),
    .drive     (drive),
    .lane_be   (lane_be),
    .capture   (capture),
    .rsp_valid (rsp_valid)
  );

  fpm_dq_lanes #(.LANES (LANES), .LANE_W (LANE_W)) u_dq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (req_take),
    .wdata_in (req_wdata),
    .drive    (drive),
    .lane_be  (lane_be),
    .capture  (capture),
    .rdata    (rsp_rdata),
    .dq       (dram_dq)
  );

  assign dram_ras_n  = ctl.ras_n;
  assign dram_we_n   = ctl.we_n;
  assign dram_oe_n   = ctl.oe_n;
  assign dram_casl_n = cas_n[0];
  assign dram_cash_n = cas_n[1];
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int AW    = 12,
  parameter int T_RP  = 5,
  parameter int T_RCD = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          ras_n,
  input logic          casl_n,
  input logic          cash_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [AW-1:0] addr
);
  localparam int SAT   = T_RP + T_RCD + 2;
  localparam int CW    = $clog2(SAT + 1);

  logic [CW-1:0] hi_cnt, lo_cnt;
  logic          any_cas;

  assign any_cas = !casl_n || !cash_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= !ras_n ? '0 : (hi_cnt == CW'(SAT) ? hi_cnt : hi_cnt + 1'b1);
      lo_cnt <=  ras_n ? '0 : (lo_cnt == CW'(SAT) ? lo_cnt : lo_cnt + 1'b1);
    end
  end

  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_cnt >= CW'(T_RP));                              // R8
  AST_RAS_TO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(casl_n) || $fell(cash_n)) && !ras_n |-> lo_cnt >= CW'(T_RCD)); // R3
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && any_cas |-> !casl_n && !cash_n && we_n);            // R9
  AST_COL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    any_cas && $past(any_cas) && !ras_n |-> $stable(addr));             // R2
  AST_COL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    any_cas && !ras_n |-> addr[AW-1:10] == '0);                         // R2
  AST_WE_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(casl_n) || $fell(cash_n)) && !we_n |-> $past(we_n) == 1'b0);  // R5
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));                                                  // R5
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);                                           // R6
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);                              // R12
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(.AW(AW), .T_RP(T_RP), .T_RCD(T_RCD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ras_n     (dram_ras_n),
  .casl_n    (dram_casl_n),
  .cash_n    (dram_cash_n),
  .we_n      (dram_we_n),
  .oe_n      (dram_oe_n),
  .addr      (dram_addr)
);

// File: tb/fpm_dram_ctrl_tb.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_tb;
  localparam int T_INIT = 20, T_RCD = 2, T_CAS = 3, T_RD = 2, T_CP = 1;
  localparam int T_RP = 3, T_CSR = 1, T_RAS = 4, REF = 300, IDLE_TO = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready, rsp_valid;
  logic [21:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0, rsp_rdata;
  logic        ras_n, casl_n, cash_n, we_n, oe_n;
  logic [11:0] dram_addr;
  wire  [15:0] dram_dq;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  fpm_dram_ctrl #(
    .T_INIT(T_INIT), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RD(T_RD), .T_CP(T_CP),
    .T_RP(T_RP), .T_CSR(T_CSR), .T_RAS(T_RAS), .REF_INTERVAL(REF), .IDLE_TO(IDLE_TO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ras_n(ras_n),
    .dram_casl_n(casl_n), .dram_cash_n(cash_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(dram_addr), .dram_dq(dram_dq)
  );

  // ---------------- memory model ----------------
  logic [15:0] mem [int unsigned];
  logic [11:0] row_l = '0;
  logic [9:0]  col_l = '0;
  logic [7:0]  rd_lo = '0, rd_hi = '0;
  int act_cnt = 0, ref_cnt = 0, cbr_bad = 0, cash_falls = 0;

  function automatic logic [15:0] peek(int unsigned k);
    return mem.exists(k) ? mem[k] : 16'h0000;
  endfunction

  always @(negedge ras_n) begin
    if (casl_n && cash_n) begin
      row_l = dram_addr;
      act_cnt++;
    end else begin
      ref_cnt++;
      if (casl_n || cash_n || !we_n) cbr_bad++;
    end
  end

  always @(negedge casl_n) if (!ras_n) begin
    logic [15:0] w;
    col_l = dram_addr[9:0];
    w = peek({row_l, col_l});
    if (!we_n) begin w[7:0] = dram_dq[7:0]; mem[{row_l, col_l}] = w; end
    rd_lo = w[7:0];
  end

  always @(negedge cash_n) if (!ras_n) begin
    logic [15:0] w;
    cash_falls++;
    col_l = dram_addr[9:0];
    w = peek({row_l, col_l});
    if (!we_n) begin w[15:8] = dram_dq[15:8]; mem[{row_l, col_l}] = w; end
    rd_hi = w[15:8];
  end

  assign dram_dq[7:0]  = (!ras_n && !casl_n && !oe_n) ? rd_lo : 8'hzz;
  assign dram_dq[15:8] = (!ras_n && !cash_n && !oe_n) ? rd_hi : 8'hzz;

  // ---------------- timing monitor (sampled at negedge) ----------------
  int hi_len = 0, lo_len = 0, last_act_hi = 999, min_ref_hi = 999, min_rcd = 999;
  logic ras_prev = 1'b1, cas_prev = 1'b1;
  always @(negedge clk) begin
    if (!ras_n && ras_prev) begin
      if (casl_n && cash_n) last_act_hi = hi_len;
      else if (hi_len < min_ref_hi) min_ref_hi = hi_len;
    end
    if (!(casl_n && cash_n) && cas_prev && !ras_n && lo_len < min_rcd) min_rcd = lo_len;
    hi_len   = ras_n ? hi_len + 1 : 0;
    lo_len   = ras_n ? 0 : lo_len + 1;
    ras_prev = ras_n;
    cas_prev = casl_n && cash_n;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [21:0] a, input logic [1:0] be, input logic [15:0] d);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    while (!req_ready && n < 1000) begin @(negedge clk); n++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R12 ready low after take", {31'b0, req_ready}, 0);
  endtask

  task automatic wr(input logic [21:0] a, input logic [1:0] be, input logic [15:0] d);
    issue(1'b1, a, be, d);
    repeat (T_RCD + T_CAS + 4) @(negedge clk);
  endtask

  task automatic rd(input logic [21:0] a, input logic [1:0] be, input logic [15:0] exp, input string req);
    int n = 0;
    issue(1'b0, a, be, 16'h0);
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    chk(rsp_valid && rsp_rdata == exp, req, {16'h0, rsp_rdata}, {16'h0, exp});
    @(negedge clk);
    chk(!rsp_valid, "R6 single-cycle rsp_valid", {31'b0, rsp_valid}, 0);
  endtask

  task automatic sync_refresh();
    int r0 = ref_cnt;
    int n = 0;
    while (ref_cnt == r0 && n < 3 * REF) begin @(negedge clk); n++; end
    repeat (T_RAS + T_RP + 4) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    int n = 0;
    repeat (3) @(negedge clk);
    chk(ras_n && casl_n && cash_n && we_n && oe_n, "R1 strobes high in reset",
        {27'b0, ras_n, casl_n, cash_n, we_n, oe_n}, 32'h1f);
    chk(!req_ready, "R1 ready low in reset", {31'b0, req_ready}, 0);
    rst_n = 1'b1;
    while (!req_ready && n < 200) begin
      @(negedge clk); n++;
      if (!(ras_n && casl_n && cash_n && we_n && oe_n)) break;
    end
    chk(n >= T_INIT && req_ready, "R1 init wait", n, T_INIT);
  endtask

  task automatic t_word();
    sync_refresh();
    wr(22'h001345, 2'b11, 16'hBEEF);
    chk(row_l == 12'h004, "R2 row address", {20'h0, row_l}, 32'h004);
    chk(col_l == 10'h345, "R2 column address", {22'h0, col_l}, 32'h345);
    rd(22'h001345, 2'b11, 16'hBEEF, "R5 R6 word read-back");
    chk(min_rcd >= T_RCD, "R3 row to column delay", min_rcd, T_RCD);
  endtask

  task automatic t_bytes();
    int c0;
    sync_refresh();
    wr(22'h002010, 2'b11, 16'hAAAA);
    c0 = cash_falls;
    wr(22'h002010, 2'b01, 16'h1234);
    chk(cash_falls == c0, "R4 high strobe idle on low-byte write", cash_falls - c0, 0);
    rd(22'h002010, 2'b11, 16'hAA34, "R4 low lane only written");
    wr(22'h002010, 2'b10, 16'h56FF);
    rd(22'h002010, 2'b11, 16'h5634, "R4 high lane only written");
    rd(22'h002010, 2'b10, 16'h5600, "R6 disabled lane reads zero");
  endtask

  task automatic t_page();
    int a0;
    sync_refresh();
    a0 = act_cnt;
    wr(22'h005001, 2'b11, 16'h1111);
    rd(22'h005001, 2'b11, 16'h1111, "R7 hit read");
    wr(22'h005002, 2'b11, 16'h2222);
    chk(act_cnt - a0 == 1, "R7 no reactivation in page", act_cnt - a0, 1);
    rd(22'h006002, 2'b11, 16'h0000, "R8 miss read");
    chk(act_cnt - a0 == 2, "R8 miss activates", act_cnt - a0, 2);
    chk(last_act_hi >= T_RP, "R8 precharge before new row", last_act_hi, T_RP);
    rd(22'h005002, 2'b11, 16'h2222, "R8 back to first row");
  endtask

  task automatic t_refresh();
    int r0;
    sync_refresh();
    r0 = ref_cnt;
    repeat (2 * REF + 10) @(negedge clk);
    chk(ref_cnt - r0 >= 2 && ref_cnt - r0 <= 3, "R9 refresh rate", ref_cnt - r0, 2);
    chk(cbr_bad == 0, "R9 column-before-row order", cbr_bad, 0);
  endtask

  task automatic t_collide();
    int r0 = ref_cnt;
    for (int i = 0; i < 40; i++) begin
      logic [21:0] a = {(i % 2) ? 12'h00A : 12'h00B, 10'(i)};
      issue(1'b1, a, 2'b11, 16'(16'hC000 + i));
      rd(a, 2'b11, 16'(16'hC000 + i), "R10 data across refresh");
    end
    chk(ref_cnt > r0, "R10 refresh inside stream", ref_cnt - r0, 1);
    chk(min_ref_hi >= T_RP, "R10 precharge before refresh", min_ref_hi, T_RP);
  endtask

  task automatic t_idle();
    sync_refresh();
    wr(22'h007003, 2'b11, 16'h7777);
    repeat (IDLE_TO / 2) @(negedge clk);
    chk(!ras_n, "R11 row kept open", {31'b0, ras_n}, 0);
    repeat (IDLE_TO / 2 + 10) @(negedge clk);
    chk(ras_n, "R11 row closed after idle", {31'b0, ras_n}, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_word();
    t_bytes();
    t_page();
    t_refresh();
    t_collide();
    t_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule